// File: doc/BRIEF.md
# Byte-Wide Window onto Sixteen-Bit Registers

This bridge sits between an 8-bit register bus and two 16-bit values: a running counter and a capture/top register. A 16-bit value cannot be moved in one bus access. Each word therefore has a low-byte address and a high-byte address, and one staging byte is shared by both words. Accesses to a high-byte address only reach the staging byte. Accesses to a low-byte address move the whole word at once. A 16-bit read therefore returns a low and a high byte taken at the same instant, and a 16-bit write lands as a single update.

Software writes the high byte first and reads the low byte first. The bridge does not enforce this order. Write commits come out as single-cycle strobes, one for the counter and one for the capture register, together with the 16-bit value. The register that owns the counter must give a commit priority over its own increment in the same cycle. The capture register accepts bytes only while the timer mode input equals the capture-top mode (12 by default).

Top module: `word_bridge`

## Requirements
- R1: After reset the staging byte is 0, so reading a high-byte address returns 0.
- R2: A write to the counter high address (offset 1) stores the data byte in the staging byte and raises no commit strobe.
- R3: A write to the counter low address (offset 0) raises `cnt_commit` in that same cycle only. `commit_data` carries the staging byte in bits 15:8 and the bus byte in bits 7:0. Consecutive low writes each commit.
- R4: A read of a low address (offset 0 for the counter, 2 for the capture register) returns bits 7:0 of the live value in the same cycle. At the next clock edge it loads bits 15:8 of that live value into the staging byte.
- R5: A read of either high address (offset 1 or 3) returns the staging byte, never the live high byte.
- R6: One staging byte serves both words. A byte staged or latched through one word is what the other word's high read returns and what the other word's commit uses.
- R7: While `mode` is not 12, a write to the capture high address (offset 3) leaves the staging byte unchanged, and a write to the capture low address (offset 2) raises no `cap_commit`. With `mode` equal to 12, both writes behave like their counter counterparts.
- R8: When a read and a write hit the same address in one cycle, the read returns the state from before the edge. A high write then updates the staging byte. A low write commits with the old staging byte while the read reloads the staging byte from the live high byte.
- R9: Any other address reads as 0, raises no commit, and leaves the staging byte unchanged.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low, and no commit strobe rises without `bus_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| mode | input | 4 | Timer mode; 12 unlocks the capture register |
| cnt_live | input | 16 | Current counter value |
| cap_live | input | 16 | Current capture register value |
| cnt_commit | output | 1 | One-cycle counter write strobe |
| cap_commit | output | 1 | One-cycle capture register write strobe |
| commit_data | output | 16 | Word to be written on either strobe |

## Verification
The tests run paired accesses in the intended order: high write followed by low write, and low read followed by high read. A moving live counter in these sequences shows that a high read returns the latched byte and not the current one. The staging byte is also carried from one word into the other. This shows that only one byte of storage exists and that either word's low access overwrites it. Capture accesses are repeated with the mode locked and then unlocked, which separates the mode gate from the address decode. Same-address read-and-write cycles, unmapped addresses and idle strobes confirm which source wins the staging byte and that nothing moves without an access.

// File: rtl/word_bridge.sv
module word_bridge #(
  parameter int ADDR_W   = 4,
  parameter int BYTE_W   = 8,
  parameter int MODE_W   = 4,
  parameter int CNT_LO   = 0,
  parameter int CNT_HI   = 1,
  parameter int CAP_LO   = 2,
  parameter int CAP_HI   = 3,
  parameter int CAP_MODE = 12,
  localparam int WORD_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [MODE_W-1:0] mode,
  input  logic [WORD_W-1:0] cnt_live,
  input  logic [WORD_W-1:0] cap_live,
  output logic              cnt_commit,
  output logic              cap_commit,
  output logic [WORD_W-1:0] commit_data
);

  logic [BYTE_W-1:0] tmp_q;

  wire cap_open = (mode == MODE_W'(CAP_MODE));
  wire at_cl = (bus_addr == ADDR_W'(CNT_LO));
  wire at_ch = (bus_addr == ADDR_W'(CNT_HI));
  wire at_pl = (bus_addr == ADDR_W'(CAP_LO));
  wire at_ph = (bus_addr == ADDR_W'(CAP_HI));

  wire stage_wr = bus_wr & (at_ch | (at_ph & cap_open));

  assign cnt_commit  = bus_wr & at_cl;
  assign cap_commit  = bus_wr & at_pl & cap_open;
  assign commit_data = {tmp_q, bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tmp_q <= '0;
    else if (stage_wr)
      tmp_q <= bus_wdata;
    else if (bus_rd && at_cl)
      tmp_q <= cnt_live[WORD_W-1:BYTE_W];
    else if (bus_rd && at_pl)
      tmp_q <= cap_live[WORD_W-1:BYTE_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (at_cl)              bus_rdata = cnt_live[BYTE_W-1:0];
      else if (at_pl)         bus_rdata = cap_live[BYTE_W-1:0];
      else if (at_ch || at_ph) bus_rdata = tmp_q;
    end
  end

  // R2: counter high write lands in the staging byte
  p_hi_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(CNT_HI)) |=> tmp_q == $past(bus_wdata));

  // R4: low read (without write) latches live high byte
  p_lo_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(CNT_LO)) |=> tmp_q == $past(cnt_live[WORD_W-1:BYTE_W]));

  // R7: locked capture high write leaves staging byte alone
  p_cap_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(CAP_HI) && mode != MODE_W'(CAP_MODE)) |=> $stable(tmp_q));

  // R7: capture commit only in capture-top mode
  p_cap_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_commit |-> mode == MODE_W'(CAP_MODE));

  // R10: no strobe without a bus write
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !cnt_commit && !cap_commit);

endmodule

// File: tb/word_bridge_tb.sv
`timescale 1ns/1ps
module word_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  mode = '0;
  logic [15:0] cnt_live = '0;
  logic [15:0] cap_live = '0;
  logic        cnt_commit, cap_commit;
  logic [15:0] commit_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_tmp = 0;

  always #2.5 clk = ~clk;

  word_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .mode(mode), .cnt_live(cnt_live), .cap_live(cap_live),
    .cnt_commit(cnt_commit), .cap_commit(cap_commit), .commit_data(commit_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against the model at negedge, advance model at posedge
  task automatic step(input int a, input bit w, input int d, input bit r, input string tag);
    int exp_rd;
    bit ec, ep;
    bus_addr = a[3:0]; bus_wr = w; bus_wdata = d[7:0]; bus_rd = r;
    @(negedge clk);
    exp_rd = 0;
    if (r) begin
      if (a == 0)               exp_rd = cnt_live[7:0];
      else if (a == 2)          exp_rd = cap_live[7:0];
      else if (a == 1 || a == 3) exp_rd = m_tmp;
    end
    ec = w && a == 0;
    ep = w && a == 2 && mode == 4'd12;
    chk({tag, " rdata"}, bus_rdata, exp_rd);
    chk({tag, " cnt_commit"}, cnt_commit, ec);
    chk({tag, " cap_commit"}, cap_commit, ep);
    if (ec || ep) chk({tag, " commit_data"}, commit_data, (m_tmp << 8) | (d & 8'hff));
    @(posedge clk);
    if (w && (a == 1 || (a == 3 && mode == 4'd12))) m_tmp = d & 8'hff;
    else if (r && a == 0) m_tmp = cnt_live[15:8];
    else if (r && a == 2) m_tmp = cap_live[15:8];
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    chk({tag, " idle rdata R10"}, bus_rdata, 0);
    chk({tag, " idle strobes R10"}, {cnt_commit, cap_commit}, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    step(1, 0, 0, 1, "R1 reset staging");
    step(3, 0, 0, 1, "R1 reset staging cap");

    cnt_live = 16'h0F0F;
    step(1, 1, 8'hA5, 0, "R2 hi write");
    step(1, 0, 0, 1, "R5 R2 hi read staged");
    step(0, 1, 8'h3C, 0, "R3 lo commit");
    step(0, 1, 8'h3D, 0, "R3 back to back");

    cnt_live = 16'h1234;
    step(0, 0, 0, 1, "R4 lo read");
    cnt_live = 16'h9999;
    step(1, 0, 0, 1, "R5 hi read latched");
    step(0, 1, 8'h00, 0, "R4 commit uses latched");

    mode = 4'd0;
    step(3, 1, 8'h77, 0, "R7 locked cap hi");
    step(1, 0, 0, 1, "R7 staging kept");
    step(2, 1, 8'h55, 0, "R7 locked cap lo");

    mode = 4'd12;
    step(3, 1, 8'h5E, 0, "R7 open cap hi");
    step(2, 1, 8'h01, 0, "R7 open cap commit");
    step(1, 0, 0, 1, "R6 shared via cnt hi");

    cap_live = 16'hBEEF;
    step(2, 0, 0, 1, "R4 R6 cap lo read");
    cap_live = 16'h0000;
    step(1, 0, 0, 1, "R6 cnt hi shows cap high");
    step(1, 1, 8'h11, 0, "R6 stage via cnt");
    step(2, 1, 8'h22, 0, "R6 cap commit shared");
    step(3, 0, 0, 1, "R6 cap hi read");

    step(9, 0, 0, 1, "R9 unmapped read");
    step(9, 1, 8'hFF, 0, "R9 unmapped write");
    step(15, 1, 8'hEE, 1, "R9 unmapped rw");
    step(1, 0, 0, 1, "R9 staging kept");

    step(1, 1, 8'h66, 1, "R8 hi rw same cycle");
    step(1, 0, 0, 1, "R8 hi rw result");
    cnt_live = 16'hC3A0;
    step(0, 1, 8'h44, 1, "R8 lo rw same cycle");
    step(1, 0, 0, 1, "R8 lo rw reload");

    mode = 4'd4;
    step(3, 0, 0, 1, "R5 cap hi read locked mode");
    step(2, 0, 0, 0, "R10 no strobes");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule